// File: doc/BRIEF.md
# Cache Maintenance Sequencer

This block runs cache maintenance commands against a small set-associative tag model that holds an instruction cache and a data cache. A command is either a plain invalidate or a push (write back dirty data, then invalidate). It covers one line, one aligned page of sets, or the whole cache, and it applies to the instruction cache, the data cache, or both. The tag model is filled through a write port and read back through a probe port.

When a command is accepted, the sequencer raises a pipeline interlock. It then waits for the drain indication to go low, which means that outstanding write-backs and prefetches have finished. After that it walks the affected set indices one per cycle, and the two caches are walked side by side. For a push, each dirty data line in scope is written out over a request/acknowledge bus before the line is dropped. A line with exactly one dirty long word goes out as a single beat. A line with more dirty words goes out as a four-beat full line.

Interrupt levels are sampled on every clock while a command is in progress, so the core never has to wait for the command to end. When the walk finishes, the interlock drops and a one-cycle done pulse marks the release.

Top module: `cm_maint_seq`

## Requirements
- R1: After a command is accepted, no set is walked and no bus beat is issued in any cycle that follows a clock edge at which `drain_busy` was high. The walk begins on the first edge at which `drain_busy` is sampled low.
- R2: `cmd_valid` is accepted only while `interlock` is low. `interlock` rises in the cycle after acceptance and stays high without a gap until the command completes.
- R3: `irq_sampled` takes the value of `irq_level` at every clock edge where a command is accepted or `interlock` is high. At all other edges it holds its value.
- R4: The scope field `cmd_scope` is decoded as follows. 00 selects the single line at set `cmd_set`, way `cmd_way`. 01 selects all ways of the PAGE_SETS-aligned group of sets that contains `cmd_set`. 10 selects every set and way.
- R5: `cmd_sel` bit 0 selects the instruction cache and bit 1 selects the data cache. After a command, every selected line in scope reads invalid and clean on the probe port. Lines in an unselected cache and lines out of scope keep their valid and dirty state.
- R6: With D edges of `drain_busy` high after acceptance, an invalidate (`cmd_push`=0) keeps `interlock` high for D+1+N cycles, where N is the number of sets in scope. This count is the same for every cache select.
- R7: A push (`cmd_push`=1) that includes the data cache writes out each valid data line in scope that has a nonzero dirty mask. Lines go out in ascending set order, and within a set in ascending way order. A single dirty word gives one beat at that word with `bus_full`=0. Two or more dirty words give four beats on words 0 to 3 with `bus_full`=1. Clean lines produce no bus request. Each pushed line adds 1 cycle plus its beats' handshake cycles to the time that `interlock` is high.
- R8: `bus_req` stays high with stable `bus_set`, `bus_way` and `bus_word` until `bus_ack` is sampled high. Each beat waits for its own acknowledge.
- R9: A pushed line stays valid until its last beat has been acknowledged. It reads invalid from the following cycle on.
- R10: `done` is high for exactly one cycle. That cycle is the first cycle with `interlock` low after a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_push | input | 1 | 1 = push and invalidate, 0 = invalidate |
| cmd_scope | input | 2 | 00 line, 01 page, 10 whole cache |
| cmd_sel | input | 2 | Bit 0 instruction cache, bit 1 data cache |
| cmd_set | input | SETW | Set index for line or page scope |
| cmd_way | input | WAYW | Way for line scope |
| drain_busy | input | 1 | Write-backs or prefetches still outstanding |
| irq_level | input | IRQW | Interrupt request level |
| fill_en | input | 1 | Tag model write strobe |
| fill_cache | input | 1 | 0 instruction, 1 data |
| fill_set | input | SETW | Set written |
| fill_way | input | WAYW | Way written |
| fill_valid | input | 1 | Valid bit written |
| fill_dirty | input | WORDS | Dirty word mask written (data cache only) |
| probe_cache | input | 1 | 0 instruction, 1 data |
| probe_set | input | SETW | Set probed |
| probe_way | input | WAYW | Way probed |
| probe_valid | output | 1 | Valid bit of probed line |
| probe_dirty | output | WORDS | Dirty mask of probed line (zero for instruction cache) |
| bus_req | output | 1 | Push beat request |
| bus_set | output | SETW | Set of the pushed line |
| bus_way | output | WAYW | Way of the pushed line |
| bus_word | output | WORDW | Long word of the beat |
| bus_full | output | 1 | Beat belongs to a full-line push |
| bus_ack | input | 1 | Beat acknowledge |
| interlock | output | 1 | Pipeline interlock |
| done | output | 1 | One-cycle completion pulse |
| irq_sampled | output | IRQW | Last sampled interrupt level |

## Verification
The bench sweeps every operation, scope and cache select against three tag images. One image has randomly mixed valid lines with clean, single-word-dirty and multi-word-dirty masks, one has every data line fully dirty, and one has every line valid and clean. The mixed image separates the one-beat and four-beat push choices. The all-dirty image checks the worst case, where every line goes out as a full line. The clean image shows that a push with nothing dirty costs exactly as much as an invalidate and produces no bus traffic. Drain stalls of zero to two cycles and acknowledge delays of zero or one cycle are layered on top. Their effect on the interlock length shows the drain wait apart from the beat handshake, and identical counts across cache selects show that both caches are walked in parallel.

// File: rtl/cm_pkg.sv
package cm_pkg;

  typedef enum logic [1:0] {
    SC_LINE = 2'b00,
    SC_PAGE = 2'b01,
    SC_ALL  = 2'b10
  } scope_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'b00,
    S_DRAIN = 2'b01,
    S_WALK  = 2'b10,
    S_PUSH  = 2'b11
  } state_t;

endpackage

// File: rtl/cm_valid_store.sv
module cm_valid_store #(
  parameter int SETS = 16,
  parameter int WAYS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fill_en,
  input  logic [$clog2(SETS)-1:0]   fill_set,
  input  logic [$clog2(WAYS)-1:0]   fill_way,
  input  logic                      fill_valid,
  input  logic                      inv_en,
  input  logic [$clog2(SETS)-1:0]   inv_set,
  input  logic [WAYS-1:0]           inv_ways,
  input  logic [$clog2(SETS)-1:0]   rd_set,
  output logic [WAYS-1:0]           rd_valid,
  input  logic [$clog2(SETS)-1:0]   pr_set,
  input  logic [$clog2(WAYS)-1:0]   pr_way,
  output logic                      pr_valid
);
  localparam int SETW = $clog2(SETS);

  logic [WAYS-1:0] vld_q [SETS];

  for (genvar gs = 0; gs < SETS; gs++) begin : g_set
    logic [WAYS-1:0] vld_d;
    logic            row_en;

    always_comb begin
      vld_d = vld_q[gs];
      if (fill_en && fill_set == SETW'(gs)) vld_d[fill_way] = fill_valid;
      if (inv_en && inv_set == SETW'(gs))   vld_d = vld_d & ~inv_ways;
      row_en = (fill_en && fill_set == SETW'(gs)) || (inv_en && inv_set == SETW'(gs));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vld_q[gs] <= '0;
      else if (row_en) vld_q[gs] <= vld_d;
    end
  end

  assign rd_valid = vld_q[rd_set];
  assign pr_valid = vld_q[pr_set][pr_way];

endmodule

// File: rtl/cm_dirty_store.sv
module cm_dirty_store #(
  parameter int SETS  = 16,
  parameter int WAYS  = 2,
  parameter int WORDS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fill_en,
  input  logic [$clog2(SETS)-1:0]   fill_set,
  input  logic [$clog2(WAYS)-1:0]   fill_way,
  input  logic [WORDS-1:0]          fill_dirty,
  input  logic                      inv_en,
  input  logic [$clog2(SETS)-1:0]   inv_set,
  input  logic [WAYS-1:0]           inv_ways,
  input  logic [$clog2(SETS)-1:0]   rd_set,
  output logic [WAYS*WORDS-1:0]     rd_dirty,
  input  logic [$clog2(SETS)-1:0]   pr_set,
  input  logic [$clog2(WAYS)-1:0]   pr_way,
  output logic [WORDS-1:0]          pr_dirty
);
  localparam int SETW = $clog2(SETS);
  localparam int DW   = WAYS * WORDS;

  logic [DW-1:0] drt_q [SETS];

  for (genvar gs = 0; gs < SETS; gs++) begin : g_set
    logic [DW-1:0] drt_d;
    logic          row_en;

    always_comb begin
      drt_d = drt_q[gs];
      if (fill_en && fill_set == SETW'(gs))
        drt_d[int'(fill_way)*WORDS +: WORDS] = fill_dirty;
      if (inv_en && inv_set == SETW'(gs)) begin
        for (int w = 0; w < WAYS; w++)
          if (inv_ways[w]) drt_d[w*WORDS +: WORDS] = '0;
      end
      row_en = (fill_en && fill_set == SETW'(gs)) || (inv_en && inv_set == SETW'(gs));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      drt_q[gs] <= '0;
      else if (row_en) drt_q[gs] <= drt_d;
    end
  end

  assign rd_dirty = drt_q[rd_set];
  assign pr_dirty = drt_q[pr_set][int'(pr_way)*WORDS +: WORDS];

endmodule

// File: rtl/cm_push_beats.sv
module cm_push_beats #(
  parameter int SETS  = 16,
  parameter int WAYS  = 2,
  parameter int WORDS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      full,
  input  logic [$clog2(WORDS)-1:0]  first_word,
  input  logic [$clog2(SETS)-1:0]   line_set,
  input  logic [$clog2(WAYS)-1:0]   line_way,
  input  logic                      bus_ack,
  output logic                      bus_req,
  output logic [$clog2(SETS)-1:0]   bus_set,
  output logic [$clog2(WAYS)-1:0]   bus_way,
  output logic [$clog2(WORDS)-1:0]  bus_word,
  output logic                      bus_full,
  output logic                      fin
);
  localparam int SETW  = $clog2(SETS);
  localparam int WAYW  = $clog2(WAYS);
  localparam int WORDW = $clog2(WORDS);

  logic             act_q, act_d;
  logic             full_q, full_d;
  logic [WORDW-1:0] word_q, word_d;
  logic [SETW-1:0]  set_q, set_d;
  logic [WAYW-1:0]  way_q, way_d;
  logic             last_beat;
  logic             en;

  assign last_beat = !full_q || (word_q == WORDW'(WORDS-1));

  always_comb begin
    act_d  = act_q;
    full_d = full_q;
    word_d = word_q;
    set_d  = set_q;
    way_d  = way_q;
    en     = 1'b0;
    if (start) begin
      en     = 1'b1;
      act_d  = 1'b1;
      full_d = full;
      word_d = full ? '0 : first_word;
      set_d  = line_set;
      way_d  = line_way;
    end else if (act_q && bus_ack) begin
      en = 1'b1;
      if (last_beat) act_d  = 1'b0;
      else           word_d = word_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      full_q <= 1'b0;
      word_q <= '0;
      set_q  <= '0;
      way_q  <= '0;
    end else if (en) begin
      act_q  <= act_d;
      full_q <= full_d;
      word_q <= word_d;
      set_q  <= set_d;
      way_q  <= way_d;
    end
  end

  assign bus_req  = act_q;
  assign bus_set  = set_q;
  assign bus_way  = way_q;
  assign bus_word = word_q;
  assign bus_full = full_q;
  assign fin      = act_q && bus_ack && last_beat;

endmodule

// File: rtl/cm_maint_seq.sv
module cm_maint_seq
  import cm_pkg::*;
#(
  parameter int SETS      = 16,
  parameter int WAYS      = 2,
  parameter int WORDS     = 4,
  parameter int PAGE_SETS = 4,
  parameter int IRQW      = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic                      cmd_push,
  input  logic [1:0]                cmd_scope,
  input  logic [1:0]                cmd_sel,
  input  logic [$clog2(SETS)-1:0]   cmd_set,
  input  logic [$clog2(WAYS)-1:0]   cmd_way,
  input  logic                      drain_busy,
  input  logic [IRQW-1:0]           irq_level,
  input  logic                      fill_en,
  input  logic                      fill_cache,
  input  logic [$clog2(SETS)-1:0]   fill_set,
  input  logic [$clog2(WAYS)-1:0]   fill_way,
  input  logic                      fill_valid,
  input  logic [WORDS-1:0]          fill_dirty,
  input  logic                      probe_cache,
  input  logic [$clog2(SETS)-1:0]   probe_set,
  input  logic [$clog2(WAYS)-1:0]   probe_way,
  output logic                      probe_valid,
  output logic [WORDS-1:0]          probe_dirty,
  output logic                      bus_req,
  output logic [$clog2(SETS)-1:0]   bus_set,
  output logic [$clog2(WAYS)-1:0]   bus_way,
  output logic [$clog2(WORDS)-1:0]  bus_word,
  output logic                      bus_full,
  input  logic                      bus_ack,
  output logic                      interlock,
  output logic                      done,
  output logic [IRQW-1:0]           irq_sampled
);
  localparam int SETW  = $clog2(SETS);
  localparam int WAYW  = $clog2(WAYS);
  localparam int WORDW = $clog2(WORDS);
  localparam int DW    = WAYS * WORDS;
  localparam logic [SETW-1:0] PAGE_MASK = SETW'(PAGE_SETS - 1);

  state_t          state_q, state_d;
  logic            push_q, push_d;
  logic [1:0]      sel_q, sel_d;
  logic [SETW-1:0] set_q, set_d;
  logic [SETW-1:0] last_q, last_d;
  logic [WAYS-1:0] ways_q, ways_d;
  logic [WAYW-1:0] pway_q, pway_d;
  logic            done_q, done_d;
  logic [IRQW-1:0] irq_q, irq_d;
  logic            ctl_en;

  logic            accept;
  logic [SETW-1:0] cmd_first, cmd_last;
  logic [WAYS-1:0] cmd_ways;

  logic [WAYS-1:0] i_rd_valid, d_rd_valid;
  logic [DW-1:0]   d_rd_dirty;
  logic            i_pr_valid, d_pr_valid;
  logic [WORDS-1:0] d_pr_dirty;

  logic [WAYS-1:0]  cand;
  logic             has_cand;
  logic [WAYW-1:0]  pick;
  logic [WORDS-1:0] pick_mask;
  logic             pick_full;
  logic [WORDW-1:0] pick_word;
  logic             walk_inv, walk_fin;
  logic             eng_start, eng_fin;
  logic             i_inv_en, d_inv_en;
  logic [WAYS-1:0]  d_inv_ways;
  logic             pline_valid;

  assign accept    = (state_q == S_IDLE) && cmd_valid;
  assign interlock = (state_q != S_IDLE);

  // Command decode: range of sets and ways touched
  always_comb begin
    cmd_ways = '1;
    unique case (scope_t'(cmd_scope))
      SC_LINE: begin
        cmd_first = cmd_set;
        cmd_last  = cmd_set;
        cmd_ways  = WAYS'(1) << cmd_way;
      end
      SC_PAGE: begin
        cmd_first = cmd_set & ~PAGE_MASK;
        cmd_last  = cmd_set | PAGE_MASK;
      end
      default: begin
        cmd_first = '0;
        cmd_last  = SETW'(SETS - 1);
      end
    endcase
  end

  // Dirty-line selection in the set being walked
  always_comb begin
    for (int w = 0; w < WAYS; w++)
      cand[w] = ways_q[w] && d_rd_valid[w] && (|d_rd_dirty[w*WORDS +: WORDS])
                && push_q && sel_q[1];
    has_cand = 1'b0;
    pick     = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (cand[w]) begin
        has_cand = 1'b1;
        pick     = WAYW'(w);
      end
  end

  assign pick_mask = d_rd_dirty[int'(pick)*WORDS +: WORDS];

  always_comb begin
    int n;
    n         = 0;
    pick_word = '0;
    for (int b = WORDS - 1; b >= 0; b--)
      if (pick_mask[b]) begin
        n         = n + 1;
        pick_word = WORDW'(b);
      end
    pick_full = (n > 1);
  end

  // Next-state process
  always_comb begin
    state_d   = state_q;
    push_d    = push_q;
    sel_d     = sel_q;
    set_d     = set_q;
    last_d    = last_q;
    ways_d    = ways_q;
    pway_d    = pway_q;
    done_d    = 1'b0;
    eng_start = 1'b0;
    walk_inv  = 1'b0;
    walk_fin  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (cmd_valid) begin
          state_d = S_DRAIN;
          push_d  = cmd_push;
          sel_d   = cmd_sel;
          set_d   = cmd_first;
          last_d  = cmd_last;
          ways_d  = cmd_ways;
        end
      end
      S_DRAIN: begin
        if (!drain_busy) state_d = S_WALK;
      end
      S_WALK: begin
        if (has_cand) begin
          eng_start = 1'b1;
          pway_d    = pick;
          state_d   = S_PUSH;
        end else begin
          walk_inv = 1'b1;
          if (set_q == last_q) begin
            walk_fin = 1'b1;
            state_d  = S_IDLE;
            done_d   = 1'b1;
          end else begin
            set_d = set_q + 1'b1;
          end
        end
      end
      default: begin
        if (eng_fin) state_d = S_WALK;
      end
    endcase
  end

  assign ctl_en = accept || interlock;

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      push_q  <= 1'b0;
      sel_q   <= '0;
      set_q   <= '0;
      last_q  <= '0;
      ways_q  <= '0;
      pway_q  <= '0;
    end else if (ctl_en) begin
      state_q <= state_d;
      push_q  <= push_d;
      sel_q   <= sel_d;
      set_q   <= set_d;
      last_q  <= last_d;
      ways_q  <= ways_d;
      pway_q  <= pway_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign irq_d = irq_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= '0;
    else if (ctl_en) irq_q <= irq_d;
  end

  assign done        = done_q;
  assign irq_sampled = irq_q;

  // Invalidate controls for both caches
  assign i_inv_en   = walk_inv && sel_q[0];
  assign d_inv_en   = (walk_inv && sel_q[1]) || eng_fin;
  assign d_inv_ways = (state_q == S_PUSH) ? (WAYS'(1) << pway_q) : ways_q;
  assign pline_valid = d_rd_valid[pway_q];

  cm_valid_store #(.SETS(SETS), .WAYS(WAYS)) u_ivld (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en && !fill_cache), .fill_set(fill_set), .fill_way(fill_way),
    .fill_valid(fill_valid),
    .inv_en(i_inv_en), .inv_set(set_q), .inv_ways(ways_q),
    .rd_set(set_q), .rd_valid(i_rd_valid),
    .pr_set(probe_set), .pr_way(probe_way), .pr_valid(i_pr_valid)
  );

  cm_valid_store #(.SETS(SETS), .WAYS(WAYS)) u_dvld (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en && fill_cache), .fill_set(fill_set), .fill_way(fill_way),
    .fill_valid(fill_valid),
    .inv_en(d_inv_en), .inv_set(set_q), .inv_ways(d_inv_ways),
    .rd_set(set_q), .rd_valid(d_rd_valid),
    .pr_set(probe_set), .pr_way(probe_way), .pr_valid(d_pr_valid)
  );

  cm_dirty_store #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS)) u_ddrt (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en && fill_cache), .fill_set(fill_set), .fill_way(fill_way),
    .fill_dirty(fill_dirty),
    .inv_en(d_inv_en), .inv_set(set_q), .inv_ways(d_inv_ways),
    .rd_set(set_q), .rd_dirty(d_rd_dirty),
    .pr_set(probe_set), .pr_way(probe_way), .pr_dirty(d_pr_dirty)
  );

  cm_push_beats #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS)) u_push (
    .clk(clk), .rst_n(rst_n),
    .start(eng_start), .full(pick_full), .first_word(pick_word),
    .line_set(set_q), .line_way(pick),
    .bus_ack(bus_ack), .bus_req(bus_req), .bus_set(bus_set), .bus_way(bus_way),
    .bus_word(bus_word), .bus_full(bus_full), .fin(eng_fin)
  );

  assign probe_valid = probe_cache ? d_pr_valid : i_pr_valid;
  assign probe_dirty = probe_cache ? d_pr_dirty : '0;

endmodule

// File: rtl/cm_maint_seq_chk.sv
module cm_maint_seq_chk
  import cm_pkg::*;
#(
  parameter int SETS = 16,
  parameter int WAYS = 2,
  parameter int WORDS = 4,
  parameter int IRQW = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     accept,
  input logic                     interlock,
  input logic                     done,
  input logic                     drain_busy,
  input state_t                   state_q,
  input logic                     push_q,
  input logic [1:0]               sel_q,
  input logic [WAYS-1:0]          ways_q,
  input logic [WAYS-1:0]          i_rd_valid,
  input logic [WAYS-1:0]          d_rd_valid,
  input logic                     walk_fin,
  input logic                     bus_req,
  input logic                     bus_ack,
  input logic [$clog2(SETS)-1:0]  bus_set,
  input logic [$clog2(WAYS)-1:0]  bus_way,
  input logic [$clog2(WORDS)-1:0] bus_word,
  input logic [IRQW-1:0]          irq_level,
  input logic [IRQW-1:0]          irq_sampled,
  input logic                     pline_valid,
  input logic                     eng_fin
);

  p_drain_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DRAIN && drain_busy) |=> (state_q == S_DRAIN && !bus_req));

  p_lock_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> interlock);

  p_req_under_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> interlock);

  p_irq_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept || interlock) |=> (irq_sampled == $past(irq_level)));

  p_irq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !interlock) |=> $stable(irq_sampled));

  p_scope_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    walk_fin |=> ((!sel_q[0] || (i_rd_valid & ways_q) == '0) &&
                  (!sel_q[1] || (d_rd_valid & ways_q) == '0)));

  p_push_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (push_q && sel_q[1]));

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=>
      (bus_req && $stable(bus_set) && $stable(bus_way) && $stable(bus_word)));

  p_line_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PUSH) |-> pline_valid);

  p_line_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PUSH && eng_fin) |=> !pline_valid);

  p_done_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!interlock && $past(interlock)));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind cm_maint_seq cm_maint_seq_chk #(
  .SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .IRQW(IRQW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .interlock(interlock), .done(done),
  .drain_busy(drain_busy), .state_q(state_q), .push_q(push_q), .sel_q(sel_q),
  .ways_q(ways_q), .i_rd_valid(i_rd_valid), .d_rd_valid(d_rd_valid),
  .walk_fin(walk_fin), .bus_req(bus_req), .bus_ack(bus_ack), .bus_set(bus_set),
  .bus_way(bus_way), .bus_word(bus_word), .irq_level(irq_level),
  .irq_sampled(irq_sampled), .pline_valid(pline_valid), .eng_fin(eng_fin)
);

// File: tb/cm_maint_seq_tb.sv
`timescale 1ns/1ps
module cm_maint_seq_tb;
  localparam int SETS = 16, WAYS = 2, WORDS = 4, PS = 4, IRQW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid = 0, cmd_push = 0;
  logic [1:0] cmd_scope = 0, cmd_sel = 0;
  logic [3:0] cmd_set = 0;
  logic       cmd_way = 0;
  logic drain_busy = 0;
  logic [2:0] irq_level = 0;
  logic fill_en = 0, fill_cache = 0, fill_valid = 0;
  logic [3:0] fill_set = 0;
  logic       fill_way = 0;
  logic [3:0] fill_dirty = 0;
  logic probe_cache = 0;
  logic [3:0] probe_set = 0;
  logic       probe_way = 0;
  logic probe_valid;
  logic [3:0] probe_dirty;
  logic bus_req, bus_full, bus_ack = 0;
  logic [3:0] bus_set;
  logic       bus_way;
  logic [1:0] bus_word;
  logic interlock, done;
  logic [2:0] irq_sampled;

  int nchk = 0, nfail = 0;
  bit         mv [2][SETS][WAYS];
  bit [3:0]   md [SETS][WAYS];

  always #2.5 clk = ~clk;

  cm_maint_seq #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .PAGE_SETS(PS), .IRQW(IRQW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_push(cmd_push),
    .cmd_scope(cmd_scope), .cmd_sel(cmd_sel), .cmd_set(cmd_set), .cmd_way(cmd_way),
    .drain_busy(drain_busy), .irq_level(irq_level), .fill_en(fill_en),
    .fill_cache(fill_cache), .fill_set(fill_set), .fill_way(fill_way),
    .fill_valid(fill_valid), .fill_dirty(fill_dirty), .probe_cache(probe_cache),
    .probe_set(probe_set), .probe_way(probe_way), .probe_valid(probe_valid),
    .probe_dirty(probe_dirty), .bus_req(bus_req), .bus_set(bus_set),
    .bus_way(bus_way), .bus_word(bus_word), .bus_full(bus_full), .bus_ack(bus_ack),
    .interlock(interlock), .done(done), .irq_sampled(irq_sampled)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int unsigned hsh(input int unsigned a);
    return ((a * 32'd1103515245) + 32'd12345) >> 8;
  endfunction

  // Probe every line of both caches against the model; returns mismatch count
  task automatic probe_all(output int bad, output int first_act, output int first_exp);
    bad = 0; first_act = 0; first_exp = 0;
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          int a, e;
          probe_cache = c[0]; probe_set = s[3:0]; probe_way = w[0];
          #0.1;
          a = {probe_valid, probe_dirty};
          e = {mv[c][s][w], (c == 1) ? md[s][w] : 4'h0};
          if (a != e) begin
            if (bad == 0) begin first_act = a; first_exp = e; end
            bad++;
          end
        end
  endtask

  task automatic run_one(input int idx, input bit op, input int scope, input int sel,
                         input int pat, input int dly, input int wt);
    int first, last, nexp, cyc_exp, cyc, dn, bi, wcnt, kdone, bad, fa, fe, nbad_beat;
    bit irq_bad, prev_busy, quiet_bad;
    logic [2:0] prev_irq, exp_irq;
    bit [1:0] wmask;
    int es[128], ew[128], ewd[128];
    bit ef[128];
    int cset, cway;
    cset = (idx * 5 + 3) % SETS;
    cway = idx % WAYS;

    // Fill the tag model
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          int unsigned h;
          bit v; bit [3:0] d;
          h = hsh(s * 37 + w * 11 + c * 5 + idx * 131 + 7);
          if (pat == 0) begin
            v = h[0] | h[1];
            case (h[3:2])
              2'd0: d = 4'h0;
              2'd1: d = 4'b0001 << h[5:4];
              default: d = h[9:6] | 4'b1001;
            endcase
          end else if (pat == 1) begin
            v = 1'b1; d = 4'hF;
          end else begin
            v = 1'b1; d = 4'h0;
          end
          if (c == 0) d = 4'h0;
          @(negedge clk);
          fill_en = 1; fill_cache = c[0]; fill_set = s[3:0]; fill_way = w[0];
          fill_valid = v; fill_dirty = d;
          mv[c][s][w] = v;
          if (c == 1) md[s][w] = d;
        end

    // Scope (R4)
    if (scope == 0)      begin first = cset; last = cset; wmask = 2'b01 << cway; end
    else if (scope == 1) begin first = cset - cset % PS; last = first + PS - 1; wmask = 2'b11; end
    else                 begin first = 0; last = SETS - 1; wmask = 2'b11; end

    // Expected beats and cycle count (R6, R7)
    nexp = 0;
    cyc_exp = dly + 1 + (last - first + 1);
    for (int s = first; s <= last; s++)
      for (int w = 0; w < WAYS; w++)
        if (wmask[w] && op && sel[1] && mv[1][s][w] && md[s][w] != 0) begin
          if ($countones(md[s][w]) == 1) begin
            int lw = 0;
            for (int b = 3; b >= 0; b--) if (md[s][w][b]) lw = b;
            es[nexp] = s; ew[nexp] = w; ewd[nexp] = lw; ef[nexp] = 0; nexp++;
            cyc_exp += 1 + (wt + 1);
          end else begin
            for (int b = 0; b < 4; b++) begin
              es[nexp] = s; ew[nexp] = w; ewd[nexp] = b; ef[nexp] = 1; nexp++;
            end
            cyc_exp += 1 + 4 * (wt + 1);
          end
        end
    // Expected final state (R5)
    for (int c = 0; c < 2; c++)
      if (sel[c])
        for (int s = first; s <= last; s++)
          for (int w = 0; w < WAYS; w++)
            if (wmask[w]) begin
              mv[c][s][w] = 0;
              if (c == 1) md[s][w] = 0;
            end

    exp_irq = irq_sampled;
    @(negedge clk);
    fill_en = 0;
    cmd_valid = 1; cmd_push = op; cmd_scope = scope[1:0]; cmd_sel = sel[1:0];
    cmd_set = cset[3:0]; cmd_way = cway[0];
    irq_level = 3'((idx * 3 + 1) % 8);
    prev_irq = irq_level; prev_busy = 1;
    cyc = 0; dn = 0; bi = 0; wcnt = 0; kdone = 0; nbad_beat = 0; irq_bad = 0;
    for (int k = 1; k <= 4000; k++) begin
      @(negedge clk);
      cmd_valid = 0;
      drain_busy = (k <= dly);
      if (prev_busy) exp_irq = prev_irq;
      if (irq_sampled !== exp_irq) irq_bad = 1;
      if (bus_ack) wcnt = 0;
      bus_ack = 0;
      if (bus_req) begin
        if (wcnt == wt) begin
          bus_ack = 1;
          if (bi >= nexp || bus_set != es[bi][3:0] || bus_way != ew[bi][0] ||
              bus_word != ewd[bi][1:0] || bus_full != ef[bi]) nbad_beat++;
          bi++;
        end else wcnt++;
      end
      if (interlock) cyc++;
      prev_busy = interlock;
      irq_level = 3'((k * 5 + idx) % 8);
      prev_irq = irq_level;
      if (done) begin dn++; kdone = k; break; end
    end
    quiet_bad = 0;
    for (int q = 0; q < 3; q++) begin
      @(negedge clk);
      if (prev_busy) exp_irq = prev_irq;
      if (irq_sampled !== exp_irq) irq_bad = 1;
      if (done || interlock || bus_req) quiet_bad = 1;
      prev_busy = 0;
      irq_level = 3'(q + idx);
      prev_irq = irq_level;
    end

    chk(dn == 1, "R10 done pulse seen once", dn, 1);
    chk(!quiet_bad, "R10 quiet after done", quiet_bad, 0);
    chk(cyc == kdone - 1, "R2 interlock unbroken", cyc, kdone - 1);
    if (op == 0 || !sel[1])
      chk(cyc == cyc_exp, "R1 R6 interlock length", cyc, cyc_exp);
    else
      chk(cyc == cyc_exp, "R1 R7 interlock length", cyc, cyc_exp);
    chk(bi == nexp, "R7 beat count", bi, nexp);
    chk(nbad_beat == 0, "R7 R8 beat order and fields", nbad_beat, 0);
    chk(!irq_bad, "R3 interrupt sampling", irq_bad, 0);
    probe_all(bad, fa, fe);
    chk(bad == 0, "R4 R5 R9 tag state after command", fa, fe);
  endtask

  initial begin
    int bad, fa, fe;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(interlock == 0 && done == 0 && bus_req == 0, "R2 reset idle outputs",
        {interlock, done, bus_req}, 0);
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          mv[c][s][w] = 0;
          md[s][w] = 0;
        end
    probe_all(bad, fa, fe);
    chk(bad == 0, "R5 reset tag state", fa, fe);

    begin
      int idx;
      idx = 0;
      for (int op = 0; op < 2; op++)
        for (int sc = 0; sc < 3; sc++)
          for (int sl = 1; sl < 4; sl++)
            for (int pt = 0; pt < 3; pt++)
              for (int wt = 0; wt < 2; wt++) begin
                run_one(idx, op[0], sc, sl, pt, idx % 3, wt);
                idx++;
              end
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  // Watchdog
  initial begin
    #900000;
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule